// File: doc/BRIEF.md
# Lockable Thermal Trip Register Block

This block is the register front end of an on-die temperature monitor. Firmware programs three settings through a single-cycle register port: an 8-bit critical temperature limit in degrees Centigrade, a 32-bit calibration slope, and an enable for the hardware shutdown response. The block samples an 8-bit temperature reading every clock. It drives a shutdown output that latches once the response is enabled and the reading reaches the limit.

A write-1-once lock bit freezes the limit, the slope and the shutdown enable as a group. Once firmware has set it, software cannot lower the protection by turning off the shutdown response, by moving the limit, or by changing the slope. The lock clears only on the global active-low reset. The block has no other reset input, so no local reset path can release the lock.

Top module: `thermal_guard_regs`

## Requirements
- R1: After reset, the limit reads 125, and the calibration, lock, shutdown enable, temperature and shutdown output all read 0.
- R2: While unlocked, a write to offset 0x00 stores wdata[7:0] as the limit. A read of 0x00 returns the limit in bits [7:0], with bits [31:8] read as zero.
- R3: While unlocked, a write to offset 0x04 stores all 32 bits of the calibration slope. A read of 0x04 returns the stored value.
- R4: At offset 0x08, bit [0] is the lock. Writing 1 sets it. Writing 0 has no effect. Once set, it stays set until rst_n goes low. Bits [31:1] read as zero.
- R5: While the lock is set, writes to 0x00, 0x04 and 0x0C leave the limit, the calibration and the shutdown enable unchanged.
- R6: At offset 0x0C, bit [1] is the shutdown enable and is writable while unlocked. All other bits of 0x0C read as zero.
- R7: A read of offset 0x10 returns in bits [7:0] the temp_in value sampled at the previous clock edge, with the upper bits zero. Writes to 0x10 have no effect.
- R8: If a clock edge sees the shutdown enable set and temp_in greater than or equal to the limit, shutdown is high after that edge. Shutdown then stays high until reset.
- R9: Reads of unmapped offsets return zero. While rd_en is low, rdata is zero.
- R10: Shutdown never rises while the shutdown enable is clear, whatever the temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global active-low reset; the only way to clear the lock |
| addr | input | ADDR_W | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Combinational read data from the addressed register |
| temp_in | input | 8 | Current temperature reading in degrees Centigrade |
| shutdown | output | 1 | Latched hardware shutdown request |

## Verification
The comparator is driven with a temperature one degree below the limit, exactly at the limit, and well above the limit with the enable clear. These three cases separate an inclusive compare from a strict one, and show whether the enable gate works. A temperature that falls back after a trip shows whether the output is latched or only follows the compare. Protected writes are tried before the lock, after the lock, and after an attempted write of 0 to the lock. A mid-run reset shows that only the global reset releases the lock and restores the default limit.

// File: rtl/thermal_guard_regs.sv
module thermal_guard_regs #(
  parameter int ADDR_W    = 8,
  parameter int TEMP_W    = 8,
  parameter int LIMIT_RST = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              shutdown
);
  localparam logic [ADDR_W-1:0] OFS_LIMIT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CALIB = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_LOCK  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_EN    = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_TEMP  = ADDR_W'(8'h10);
  localparam int                PAD_W     = 32 - TEMP_W;

  logic [TEMP_W-1:0] limit_q, temp_q;
  logic [31:0]       calib_q;
  logic              lock_q, en_q, trip_q;

  wire open_wr = wr_en && !lock_q;
  wire over    = en_q && (temp_in >= limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= TEMP_W'(LIMIT_RST);
      calib_q <= '0;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      temp_q  <= '0;
      trip_q  <= 1'b0;
    end else begin
      temp_q <= temp_in;
      if (over) trip_q <= 1'b1;
      if (wr_en && addr == OFS_LOCK && wdata[0]) lock_q <= 1'b1;
      if (open_wr && addr == OFS_LIMIT) limit_q <= wdata[TEMP_W-1:0];
      if (open_wr && addr == OFS_CALIB) calib_q <= wdata;
      if (open_wr && addr == OFS_EN)    en_q    <= wdata[1];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_LIMIT: rdata = {{PAD_W{1'b0}}, limit_q};
        OFS_CALIB: rdata = calib_q;
        OFS_LOCK:  rdata = {31'b0, lock_q};
        OFS_EN:    rdata = {30'b0, en_q, 1'b0};
        OFS_TEMP:  rdata = {{PAD_W{1'b0}}, temp_q};
        default:   rdata = '0;
      endcase
    end
  end

  assign shutdown = trip_q;
endmodule

// File: rtl/thermal_guard_regs_chk.sv
module thermal_guard_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       rdata,
  input logic [TEMP_W-1:0] temp_in,
  input logic              shutdown,
  input logic [TEMP_W-1:0] limit_q,
  input logic [31:0]       calib_q,
  input logic              lock_q,
  input logic              en_q
);
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_locked_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && addr == ADDR_W'(8'h00)) |=> $stable(limit_q));

  assert_locked_calib_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && addr == ADDR_W'(8'h04)) |=> $stable(calib_q));

  assert_locked_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && addr == ADDR_W'(8'h0C)) |=> $stable(en_q));

  assert_trip_on_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && temp_in >= limit_q) |=> shutdown);

  assert_trip_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  assert_no_trip_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !shutdown) |=> !shutdown);

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'h0);

  assert_limit_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h00)) |-> rdata[31:8] == 24'h0);
endmodule

bind thermal_guard_regs thermal_guard_regs_chk #(.ADDR_W(ADDR_W), .TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .temp_in(temp_in), .shutdown(shutdown),
  .limit_q(limit_q), .calib_q(calib_q), .lock_q(lock_q), .en_q(en_q)
);

// File: tb/tb_thermal_guard_regs.sv
module tb_thermal_guard_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  temp_in = '0;
  logic        shutdown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_limit, m_temp;
  logic [31:0] m_calib;
  bit m_lock, m_en, m_sd;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_guard_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .temp_in(temp_in), .shutdown(shutdown)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a, input bit rd);
    if (!rd) return 32'h0;
    case (a)
      8'h00: return 32'(m_limit);
      8'h04: return m_calib;
      8'h08: return {31'b0, m_lock};
      8'h0C: return m_en ? 32'h2 : 32'h0;
      8'h10: return 32'(m_temp);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_limit = 125; m_temp = 0; m_calib = '0;
    m_lock = 0; m_en = 0; m_sd = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input string tag, input logic [7:0] a, input logic [31:0] d,
                      input bit wr, input bit rd, input logic [7:0] t);
    logic [31:0] exp_rd;
    addr = a; wdata = d; wr_en = wr; rd_en = rd; temp_in = t;
    #1;
    exp_rd = model_read(a, rd);
    checks++;
    if (rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, rdata, exp_rd);
    end
    checks++;
    if (shutdown !== m_sd) begin
      errors++;
      $display("FAIL %s shutdown actual=%b expected=%b", tag, shutdown, m_sd);
    end
    @(posedge clk);
    if (m_en && int'(t) >= m_limit) m_sd = 1;
    if (wr) begin
      case (a)
        8'h00: if (!m_lock) m_limit = int'(d[7:0]);
        8'h04: if (!m_lock) m_calib = d;
        8'h08: if (d[0]) m_lock = 1;
        8'h0C: if (!m_lock) m_en = d[1];
        default: ;
      endcase
    end
    m_temp = int'(t);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R1 reset values
    step("R1", 8'h00, 0, 0, 1, 8'd0);
    step("R1", 8'h04, 0, 0, 1, 8'd0);
    step("R1", 8'h08, 0, 0, 1, 8'd0);
    step("R1", 8'h0C, 0, 0, 1, 8'd0);
    step("R1", 8'h10, 0, 0, 1, 8'd0);
    // R9 unmapped and idle reads
    step("R9", 8'h14, 0, 0, 1, 8'd0);
    step("R9", 8'h02, 0, 0, 1, 8'd0);
    step("R9", 8'h00, 0, 0, 0, 8'd0);
    // R2 limit write with upper bits set
    step("R2", 8'h00, 32'h1234_56AA, 1, 0, 8'd0);
    step("R2", 8'h00, 0, 0, 1, 8'd0);
    // R3 calibration
    step("R3", 8'h04, 32'hDEAD_BEEF, 1, 0, 8'd0);
    step("R3", 8'h04, 0, 0, 1, 8'd0);
    // R6 enable field
    step("R6", 8'h0C, 32'hFFFF_FFFF, 1, 0, 8'd0);
    step("R6", 8'h0C, 0, 0, 1, 8'd0);
    step("R6", 8'h0C, 32'hFFFF_FFFD, 1, 0, 8'd0);
    step("R6", 8'h0C, 0, 0, 1, 8'd0);
    // R7 temperature readback, write ignored
    step("R7", 8'h10, 32'h55, 1, 0, 8'd10);
    step("R7", 8'h10, 0, 0, 1, 8'd33);
    step("R7", 8'h10, 0, 0, 1, 8'd33);
    // R10 over limit with enable clear
    step("R10", 8'h00, 32'd50, 1, 0, 8'd200);
    for (int i = 0; i < 4; i++) step("R10", 8'h10, 0, 0, 1, 8'd255);
    // R8 inclusive compare and latch
    step("R8", 8'h0C, 32'h2, 1, 0, 8'd49);
    step("R8", 8'h10, 0, 0, 1, 8'd49);
    step("R8", 8'h10, 0, 0, 1, 8'd50);
    step("R8", 8'h10, 0, 0, 1, 8'd0);
    step("R8", 8'h10, 0, 0, 1, 8'd0);
    // R4/R5 lock behaviour
    do_reset();
    step("R1", 8'h00, 0, 0, 1, 8'd0);
    step("R4", 8'h00, 32'd100, 1, 0, 8'd0);
    step("R4", 8'h08, 32'h0, 1, 0, 8'd0);
    step("R4", 8'h08, 0, 0, 1, 8'd0);
    step("R4", 8'h08, 32'h1, 1, 0, 8'd0);
    step("R4", 8'h08, 0, 0, 1, 8'd0);
    step("R5", 8'h00, 32'd3, 1, 0, 8'd0);
    step("R5", 8'h00, 0, 0, 1, 8'd0);
    step("R5", 8'h04, 32'hCAFE_F00D, 1, 0, 8'd0);
    step("R5", 8'h04, 0, 0, 1, 8'd0);
    step("R5", 8'h0C, 32'h2, 1, 0, 8'd0);
    step("R5", 8'h0C, 0, 0, 1, 8'd255);
    step("R5", 8'h10, 0, 0, 1, 8'd255);
    step("R4", 8'h08, 32'h0, 1, 0, 8'd0);
    step("R4", 8'h08, 0, 0, 1, 8'd0);
    // R4 only reset clears lock; limit restored
    do_reset();
    step("R4", 8'h08, 0, 0, 1, 8'd0);
    step("R1", 8'h00, 0, 0, 1, 8'd0);
    // R8 equality at default limit
    step("R8", 8'h0C, 32'h2, 1, 0, 8'd0);
    step("R8", 8'h10, 0, 0, 1, 8'd124);
    step("R8", 8'h10, 0, 0, 1, 8'd125);
    step("R8", 8'h10, 0, 0, 1, 8'd10);
    finish_run();
  end
endmodule